// File: doc/BRIEF.md
# Selectable Collision Backoff Controller

After a collision on a shared serial medium, this block decides when the local transmitter may try again. The jam logic gives it a start pulse when the jam has finished. The block then waits for the receive line to go idle. After that it counts slot times under one of three schemes chosen by a 3-bit select. When the wait is over, it gives a one-cycle retry-permitted pulse.

In the two random schemes the number of slots to wait comes from a free-running 16-bit LFSR. The count is masked to a window of 2^e values, where e is the number of collisions seen so far, capped at a parameter. One random scheme starts counting as soon as the line is idle. The other also waits for an inter-frame-space strobe before it starts counting. The deterministic scheme waits the node's own programmed slot number.

Top module: `collision_backoff`

## Requirements
- R1: While reset is held, and after reset until a start pulse is accepted, `retry_o` stays low whatever the other inputs do.
- R2: The select is sampled on the accepted start pulse. 3'b011 is alternate random, 3'b111 is deterministic, and every other code is normal random.
- R3: After a start pulse, slot strobes are ignored until `line_idle_i` has been seen. No retry can occur before that.
- R4: Normal random: the wait is N slot strobes, counted from the cycle after line idle is sampled, with 0 <= N <= 2^e - 1.
- R5: Alternate random: slot strobes are ignored, and no retry occurs, until `ifs_done_i` pulses after line idle. Counting of N (same range as R4) then begins.
- R6: Deterministic: the wait is exactly `node_slot_i` slot strobes, with the slot number sampled when line idle is seen.
- R7: `retry_o` is a single-cycle pulse, after which the block is idle. A start pulse or a select change while a backoff is in progress has no effect.
- R8: e is the count of accepted start pulses since reset, saturating at MAX_EXP. The window widens from 0..1 up to 0..2^MAX_EXP-1.
- R9: The LFSR (x^16+x^14+x^13+x^11, nonzero seed) never holds zero.
- R10: `retry_o` rises one cycle after the remaining count reaches zero, or one cycle after counting begins when N is zero. Without a slot strobe the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Jam-finished pulse that opens a backoff |
| algo_sel_i | input | 3 | Scheme select |
| line_idle_i | input | 1 | Receive line idle indication |
| slot_tick_i | input | 1 | One pulse per slot time |
| ifs_done_i | input | 1 | Inter-frame space elapsed pulse |
| node_slot_i | input | SLOT_W | Node's own slot number |
| retry_o | output | 1 | Retry-permitted pulse |

## Verification
The bench builds the block with SLOT_W=6 and MAX_EXP=3. With MAX_EXP=3 the exponent saturates after the third collision, so a short run covers the whole widening of the window and then a long stretch at the capped 0..7 range. SLOT_W=6 keeps the deterministic waits short while still covering slot zero and slots above the random window. Each random wait is checked against the window that the bench computes from its own collision count, and each deterministic wait is checked exactly.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  typedef enum logic [1:0] {MODE_NORM, MODE_ALT, MODE_DET} mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WIDLE, ST_WIFS, ST_COUNT} state_e;

  function automatic mode_e decode_mode(input logic [2:0] sel);
    case (sel)
      3'b011:  return MODE_ALT;
      3'b111:  return MODE_DET;
      default: return MODE_NORM;
    endcase
  endfunction
endpackage

// File: rtl/backoff_lfsr.sv
module backoff_lfsr #(
  parameter int          OUT_W = 8,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o,
  output logic [15:0]      state_o
);
  logic [15:0] q;
  logic        fb;

  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= SEED;
    else         q <= {q[14:0], fb};
  end

  assign rnd_o   = q[OUT_W-1:0];
  assign state_o = q;
endmodule

// File: rtl/backoff_window.sv
module backoff_window #(
  parameter int SLOT_W = 8,
  parameter int EXP_W  = 4
) (
  input  logic [EXP_W-1:0]  exp_i,
  output logic [SLOT_W-1:0] mask_o
);
  for (genvar i = 0; i < SLOT_W; i++) begin : g_bit
    assign mask_o[i] = (32'(exp_i) > i);
  end
endmodule

// File: rtl/backoff_slot_cnt.sv
module backoff_slot_cnt #(
  parameter int SLOT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic [SLOT_W-1:0] remain_o,
  output logic              zero_o
);
  logic [SLOT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign remain_o = cnt_q;
  assign zero_o   = (cnt_q == '0);
endmodule

// File: rtl/collision_backoff.sv
module collision_backoff
  import backoff_pkg::*;
#(
  parameter int          SLOT_W  = 8,
  parameter int          MAX_EXP = 8,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        algo_sel_i,
  input  logic              line_idle_i,
  input  logic              slot_tick_i,
  input  logic              ifs_done_i,
  input  logic [SLOT_W-1:0] node_slot_i,
  output logic              retry_o
);
  localparam int EXP_W = $clog2(MAX_EXP + 1);
  localparam logic [EXP_W-1:0] EXP_MAX = EXP_W'(MAX_EXP);

  state_e            state_q;
  mode_e             mode_q;
  logic [EXP_W-1:0]  coll_q;
  logic              retry_q;
  logic [SLOT_W-1:0] rnd, mask, target, remain;
  logic [15:0]       lfsr_state;
  logic              cnt_load, cnt_dec, cnt_zero;

  backoff_lfsr #(.OUT_W(SLOT_W), .SEED(SEED)) i_lfsr (
    .clk_i, .rst_ni, .rnd_o(rnd), .state_o(lfsr_state)
  );

  backoff_window #(.SLOT_W(SLOT_W), .EXP_W(EXP_W)) i_window (
    .exp_i(coll_q), .mask_o(mask)
  );

  assign target   = (mode_q == MODE_DET) ? node_slot_i : (rnd & mask);
  assign cnt_load = (state_q == ST_WIDLE) && line_idle_i;
  assign cnt_dec  = (state_q == ST_COUNT) && slot_tick_i && !cnt_zero;

  backoff_slot_cnt #(.SLOT_W(SLOT_W)) i_cnt (
    .clk_i, .rst_ni, .load_i(cnt_load), .load_val_i(target),
    .dec_i(cnt_dec), .remain_o(remain), .zero_o(cnt_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_NORM;
      coll_q  <= '0;
      retry_q <= 1'b0;
    end else begin
      retry_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= decode_mode(algo_sel_i);
          if (coll_q != EXP_MAX) coll_q <= coll_q + 1'b1;
          state_q <= ST_WIDLE;
        end
        ST_WIDLE: if (line_idle_i)
          state_q <= (mode_q == MODE_ALT) ? ST_WIFS : ST_COUNT;
        ST_WIFS: if (ifs_done_i) state_q <= ST_COUNT;
        ST_COUNT: if (cnt_zero) begin
          retry_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign retry_o = retry_q;
endmodule

// File: rtl/backoff_chk.sv
module backoff_chk
  import backoff_pkg::*;
#(
  parameter int SLOT_W  = 8,
  parameter int MAX_EXP = 8,
  parameter int EXP_W   = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              retry_o,
  input logic              slot_tick_i,
  input logic              ifs_done_i,
  input state_e            state_q,
  input logic [EXP_W-1:0]  coll_q,
  input logic [SLOT_W-1:0] remain,
  input logic [15:0]       lfsr_state
);
  // R7
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_o |=> !retry_o);
  // R3
  no_retry_before_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WIDLE) |=> !retry_o);
  // R5
  hold_for_ifs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WIFS && !ifs_done_i) |=> (state_q == ST_WIFS && !retry_o));
  // R10
  count_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT && !slot_tick_i && remain != '0) |=> $stable(remain));
  // R8
  exp_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(coll_q) <= MAX_EXP);
  // R9
  lfsr_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_state != 16'h0);
endmodule

bind collision_backoff backoff_chk #(
  .SLOT_W(SLOT_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)
) i_backoff_chk (
  .clk_i, .rst_ni, .retry_o, .slot_tick_i, .ifs_done_i,
  .state_q, .coll_q, .remain, .lfsr_state
);

// File: tb/test_collision_backoff.sv
module test_collision_backoff;
  localparam int SLOT_W  = 6;
  localparam int MAX_EXP = 3;
  localparam int NV      = 10;
  // mode: 0 normal, 1 alternate, 2 deterministic
  localparam logic [2:0]        SEL_V  [NV] = '{3'b000, 3'b011, 3'b111, 3'b001, 3'b111,
                                               3'b101, 3'b010, 3'b111, 3'b110, 3'b100};
  localparam logic [SLOT_W-1:0] SLOT_V [NV] = '{6'd9, 6'd9, 6'd5, 6'd3, 6'd0,
                                               6'd7, 6'd1, 6'd13, 6'd2, 6'd4};
  localparam int                MODE_V [NV] = '{0, 1, 2, 0, 2, 0, 0, 2, 0, 0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, line_idle = 1'b0, slot_tick = 1'b0, ifs_done = 1'b0;
  logic [2:0] algo_sel = 3'b000;
  logic [SLOT_W-1:0] node_slot = '0;
  logic retry;
  int total = 0, bad = 0, coll_m = 0, max_sat = 0;

  always #2.5 clk = ~clk;

  collision_backoff #(.SLOT_W(SLOT_W), .MAX_EXP(MAX_EXP)) i_collision_backoff (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .algo_sel_i(algo_sel),
    .line_idle_i(line_idle), .slot_tick_i(slot_tick), .ifs_done_i(ifs_done),
    .node_slot_i(node_slot), .retry_o(retry)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(posedge clk);
    #1;
  endtask

  task automatic run_backoff(input logic [2:0] sel, input logic [SLOT_W-1:0] slot,
                             input int mode, input bit busy_start, input string req);
    bit pre = 0, got = 0;
    int ticks = 0, bound;
    algo_sel = sel; node_slot = slot; start = 1'b1; cyc; start = 1'b0;
    if (coll_m < MAX_EXP) coll_m++;
    bound = (1 << coll_m) - 1;
    for (int k = 0; k < 2; k++) begin
      slot_tick = 1'b1; cyc; slot_tick = 1'b0; pre |= retry; cyc; pre |= retry;
    end
    if (busy_start) begin
      start = 1'b1; algo_sel = ~sel; cyc; start = 1'b0; pre |= retry;
    end
    line_idle = 1'b1; cyc; line_idle = 1'b0; pre |= retry;
    check(!pre, "R3 retry before line idle", pre, 0);
    if (mode == 1) begin
      pre = 0;
      for (int k = 0; k < 3; k++) begin
        slot_tick = 1'b1; cyc; slot_tick = 1'b0; pre |= retry; cyc; pre |= retry;
      end
      check(!pre, "R5 retry before ifs", pre, 0);
      ifs_done = 1'b1; cyc; ifs_done = 1'b0;
    end
    for (int g = 0; g < 80 && !got; g++) begin
      for (int w = 0; w < 3; w++) begin
        cyc;
        if (retry && !got) begin
          got = 1;
          cyc;
          check(!retry, "R7 pulse width", retry, 0);
        end
      end
      if (!got) begin
        slot_tick = 1'b1; cyc; slot_tick = 1'b0; ticks++;
      end
    end
    check(got, "R10 retry issued", got, 1);
    if (mode == 2) check(ticks == int'(slot), {req, " deterministic wait"}, ticks, int'(slot));
    else check(ticks <= bound, {req, " window (R8)"}, ticks, bound);
    if (coll_m == MAX_EXP && mode != 2 && ticks > max_sat) max_sat = ticks;
    algo_sel = sel;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R7 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    // R1 reset
    line_idle = 1'b1; slot_tick = 1'b1; ifs_done = 1'b1;
    repeat (3) cyc;
    check(!retry, "R1 retry in reset", retry, 0);
    rst_n = 1'b1;
    seen = 0;
    for (int k = 0; k < 10; k++) begin cyc; seen |= retry; end
    line_idle = 1'b0; slot_tick = 1'b0; ifs_done = 1'b0;
    check(!seen, "R1 retry without start", seen, 0);

    // table walk (R2 decode, R4/R5/R6)
    for (int v = 0; v < NV; v++)
      run_backoff(SEL_V[v], SLOT_V[v], MODE_V[v], 1'b0,
                  MODE_V[v] == 2 ? "R6" : (MODE_V[v] == 1 ? "R5" : "R4 R2"));

    // R7 busy start and select change ignored
    run_backoff(3'b111, 6'd6, 2, 1'b1, "R7 busy start");
    run_backoff(3'b011, 6'd0, 1, 1'b0, "R5");

    // R7 idle after retry
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      line_idle = 1'b1; slot_tick = 1'b1; ifs_done = 1'b1; cyc; seen |= retry;
    end
    line_idle = 1'b0; slot_tick = 1'b0; ifs_done = 1'b0;
    for (int k = 0; k < 4; k++) begin cyc; seen |= retry; end
    check(!seen, "R7 idle after retry", seen, 0);

    // R8 saturated window
    for (int k = 0; k < 20; k++) run_backoff(3'b000, 6'd0, 0, 1'b0, "R8");
    check(max_sat > 1 && max_sat <= (1 << MAX_EXP) - 1, "R8 widened window", max_sat,
          (1 << MAX_EXP) - 1);
    // R6 large slot beyond random window
    run_backoff(3'b111, 6'd40, 2, 1'b0, "R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule